// File: doc/BRIEF.md
# Cascaded Matrix Multiply Core

This block evaluates D = (A x B) x C for three square matrices of signed 8-bit integers, 16 x 16 by default. A host loads the three operands one element at a time through a single write port. A two-bit select picks the target matrix, and elements are addressed in row-major order. The write that fills the last element of C starts the computation.

Two multiply-accumulate units work on a pair of adjacent output columns at once. In the first pass they form A x B into an internal intermediate store at full precision. In the second pass they multiply that store by C into a 56-bit result store. A sequencer steps through rows, column pairs and inner-product index with no idle cycles between pairs. When every element of D is written, the ready flag rises and the host reads results through a read port with one cycle of latency.

The sequencer states are LOAD (waiting for operands), AB (issuing first-pass reads), AB_FLUSH (draining the pipeline into the intermediate store), TC (issuing second-pass reads), TC_FLUSH (draining into the result store) and READY. The transitions are:
- LOAD→AB and READY→AB on the starting write.
- AB→AB_FLUSH and TC→TC_FLUSH on the last read issue of a pass.
- AB_FLUSH→TC and TC_FLUSH→READY on the cycle of the final store write.

Top module: `cmm_core`

## Requirements
- R1: Element (r,c) of a matrix is written at address r*N+c. Select code 00 targets A, 01 targets B and 10 targets C. A write takes place at a rising edge where `wr_en` is high.
- R2: A write with select code 11 changes none of A, B or C.
- R3: After a computation, D(i,j) equals the sum over m of T(i,m)*C(m,j), where T(i,m) is the sum over n of A(i,n)*B(n,m). The result is exact for all signed 8-bit inputs, with no saturation or wrap.
- R4: Each result is presented as a 56-bit two's-complement value. Its upper bits are the sign extension of the exact result.
- R5: A computation starts on an accepted write of select 10 at the highest address (N*N-1). A write to any other C address starts nothing and leaves `ready` unchanged.
- R6: `ready` is low after reset and while a computation runs. It rises exactly N³+4 rising edges after the edge that captured the starting write, and stays high until the next start.
- R7: Host writes of any select, including a write that would otherwise start a computation, are ignored while a computation runs.
- R8: A read with `rd_en` high at a rising edge presents the word at `rd_addr` on `rd_data` after that edge. With `rd_en` low, `rd_data` holds its value.
- R9: An accepted starting write while `ready` is high drops `ready` on the next cycle. The block then recomputes D from the current contents of A, B and C.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising-edge active |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Host write strobe |
| wr_sel | input | 2 | Target matrix: 00 A, 01 B, 10 C, 11 none |
| wr_addr | input | log2(N*N) | Row-major element address for writes |
| wr_data | input | EW | Signed element value |
| rd_en | input | 1 | Result read strobe |
| rd_addr | input | log2(N*N) | Row-major result address |
| rd_data | output | OUT_W | Sign-extended result word, one cycle after the read |
| ready | output | 1 | High when all results are valid |

## Verification
The bench builds the core with N = 4, which keeps all 16 result words and the full N³+4 latency within a short run for several operand sets. The sets are identity operands, all-minimum and mixed-extreme operands that drive the intermediate and final sums to their largest magnitudes and negative signs, and pseudo-random operands. At that size the bench also sweeps every address with the unused select code and with writes issued during a computation. It then restarts the computation from the ready state after changing one element of C. Expected results are computed in integer arithmetic from the written operands.

// File: rtl/cmm_pkg.sv
package cmm_pkg;

    typedef enum logic [2:0] {
        ST_LOAD,
        ST_AB,
        ST_AB_FLUSH,
        ST_TC,
        ST_TC_FLUSH,
        ST_READY
    } cmm_state_e;

    localparam logic [1:0] SEL_A = 2'b00;
    localparam logic [1:0] SEL_B = 2'b01;
    localparam logic [1:0] SEL_C = 2'b10;

endpackage

// File: rtl/cmm_sdp_ram.sv
module cmm_sdp_ram #(
    parameter int W     = 8,
    parameter int DEPTH = 256
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     we,
    input  logic [$clog2(DEPTH)-1:0] waddr,
    input  logic [W-1:0]             wdata,
    input  logic                     re,
    input  logic [$clog2(DEPTH)-1:0] raddr,
    output logic [W-1:0]             rdata
);
    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we)
            mem[waddr] <= wdata;
    end

    // registered read port, one cycle latency, holds when not enabled
    always_ff @(posedge clk) begin
        if (rst)
            rdata <= '0;
        else if (re)
            rdata <= mem[raddr];
    end
endmodule

// File: rtl/cmm_bank2.sv
// Two column-parity banks sharing one address; even and odd words move together.
module cmm_bank2 #(
    parameter int W      = 8,
    parameter int HDEPTH = 128
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      we_e,
    input  logic                      we_o,
    input  logic [$clog2(HDEPTH)-1:0] waddr,
    input  logic [W-1:0]              wd_e,
    input  logic [W-1:0]              wd_o,
    input  logic                      re,
    input  logic [$clog2(HDEPTH)-1:0] raddr,
    output logic [W-1:0]              rq_e,
    output logic [W-1:0]              rq_o
);
    logic         we_v [2];
    logic [W-1:0] wd_v [2];
    logic [W-1:0] rq_v [2];

    assign we_v[0] = we_e;
    assign we_v[1] = we_o;
    assign wd_v[0] = wd_e;
    assign wd_v[1] = wd_o;
    assign rq_e    = rq_v[0];
    assign rq_o    = rq_v[1];

    for (genvar b = 0; b < 2; b++) begin : g_bank
        cmm_sdp_ram #(.W(W), .DEPTH(HDEPTH)) u_ram (
            .clk   (clk),
            .rst   (rst),
            .we    (we_v[b]),
            .waddr (waddr),
            .wdata (wd_v[b]),
            .re    (re),
            .raddr (raddr),
            .rdata (rq_v[b])
        );
    end
endmodule

// File: rtl/cmm_mac.sv
module cmm_mac #(
    parameter int LW    = 20,
    parameter int RWD   = 8,
    parameter int ACC_W = 32
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    en,
    input  logic                    first,
    input  logic signed [LW-1:0]    lhs,
    input  logic signed [RWD-1:0]   rhs,
    output logic signed [ACC_W-1:0] acc
);
    localparam int PW = LW + RWD;

    logic signed [PW-1:0]    prod;
    logic signed [ACC_W-1:0] prod_x;

    assign prod   = lhs * rhs;
    assign prod_x = {{(ACC_W-PW){prod[PW-1]}}, prod};

    always_ff @(posedge clk) begin
        if (rst)
            acc <= '0;
        else if (en)
            acc <= (first ? '0 : acc) + prod_x;
    end
endmodule

// File: rtl/cmm_seq.sv
module cmm_seq
    import cmm_pkg::*;
#(
    parameter int N = 16
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   start,
    output logic                   accept,
    output logic                   iss_v,
    output logic [$clog2(N)-1:0]   iss_r,
    output logic [$clog2(N)-2:0]   iss_cp,
    output logic [$clog2(N)-1:0]   iss_k,
    output logic                   phase2,
    output logic                   mac_v,
    output logic                   mac_first,
    output logic                   wr_v,
    output logic [$clog2(N)-1:0]   wr_r,
    output logic [$clog2(N)-2:0]   wr_cp,
    output logic                   ready
);
    localparam int RW  = $clog2(N);
    localparam int CPW = RW - 1;

    cmm_state_e state, nxt;

    logic           last_issue;
    logic           drained;
    logic           s1_v, s1_first, s1_last;
    logic [RW-1:0]  s1_r;
    logic [CPW-1:0] s1_cp;

    assign last_issue = iss_v && (&iss_k) && (&iss_cp) && (&iss_r);
    assign drained    = !s1_v && wr_v;

    // state register
    always_ff @(posedge clk) begin
        if (rst)
            state <= ST_LOAD;
        else
            state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_LOAD:     if (start)      nxt = ST_AB;
            ST_AB:       if (last_issue) nxt = ST_AB_FLUSH;
            ST_AB_FLUSH: if (drained)    nxt = ST_TC;
            ST_TC:       if (last_issue) nxt = ST_TC_FLUSH;
            ST_TC_FLUSH: if (drained)    nxt = ST_READY;
            ST_READY:    if (start)      nxt = ST_AB;
            default:                     nxt = ST_LOAD;
        endcase
    end

    // state-decoded outputs
    always_comb begin
        iss_v  = (state == ST_AB) || (state == ST_TC);
        phase2 = (state == ST_TC) || (state == ST_TC_FLUSH);
        ready  = (state == ST_READY);
        accept = (state == ST_LOAD) || (state == ST_READY);
    end

    // issue counters: k innermost, then column pair, then row
    always_ff @(posedge clk) begin
        if (rst) begin
            iss_k  <= '0;
            iss_cp <= '0;
            iss_r  <= '0;
        end else if (iss_v) begin
            iss_k <= iss_k + 1'b1;
            if (&iss_k) begin
                iss_cp <= iss_cp + 1'b1;
                if (&iss_cp)
                    iss_r <= iss_r + 1'b1;
            end
        end
    end

    // stage 1 lines up with RAM data, stage 2 with the finished sums
    always_ff @(posedge clk) begin
        if (rst) begin
            s1_v <= 1'b0;
            wr_v <= 1'b0;
        end else begin
            s1_v <= iss_v;
            wr_v <= s1_v && s1_last;
        end
        s1_first <= (iss_k == '0);
        s1_last  <= &iss_k;
        s1_r     <= iss_r;
        s1_cp    <= iss_cp;
        wr_r     <= s1_r;
        wr_cp    <= s1_cp;
    end

    assign mac_v     = s1_v;
    assign mac_first = s1_first;
endmodule

// File: rtl/cmm_core.sv
module cmm_core
    import cmm_pkg::*;
#(
    parameter int N     = 16,
    parameter int EW    = 8,
    parameter int OUT_W = 56
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr_en,
    input  logic [1:0]                 wr_sel,
    input  logic [$clog2(N*N)-1:0]     wr_addr,
    input  logic [EW-1:0]              wr_data,
    input  logic                       rd_en,
    input  logic [$clog2(N*N)-1:0]     rd_addr,
    output logic [OUT_W-1:0]           rd_data,
    output logic                       ready
);
    localparam int AW     = $clog2(N*N);
    localparam int HAW    = AW - 1;
    localparam int LOGN   = $clog2(N);
    localparam int CPW    = LOGN - 1;
    localparam int TEMP_W = 2*EW + LOGN;
    localparam int ACC_W  = TEMP_W + EW + LOGN;

    logic             accept, start, hw;
    logic             iss_v, phase2, mac_v, mac_first, wr_v;
    logic [LOGN-1:0]  iss_r, iss_k, wr_r;
    logic [CPW-1:0]   iss_cp, wr_cp;
    logic             ksel_q, rd_lsb_q;

    logic [EW-1:0]     a_q, b_e, b_o, c_e, c_o;
    logic [TEMP_W-1:0] t_e, t_o;
    logic [OUT_W-1:0]  d_e, d_o;

    logic signed [TEMP_W-1:0] lhs;
    logic signed [EW-1:0]     rhs_v [2];
    logic signed [ACC_W-1:0]  acc_v [2];
    logic [OUT_W-1:0]         dx_v  [2];

    assign hw    = wr_en && accept;
    assign start = hw && (wr_sel == SEL_C) && (&wr_addr);

    cmm_seq #(.N(N)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .accept    (accept),
        .iss_v     (iss_v),
        .iss_r     (iss_r),
        .iss_cp    (iss_cp),
        .iss_k     (iss_k),
        .phase2    (phase2),
        .mac_v     (mac_v),
        .mac_first (mac_first),
        .wr_v      (wr_v),
        .wr_r      (wr_r),
        .wr_cp     (wr_cp),
        .ready     (ready)
    );

    // A: left operand of pass one, read along a row
    cmm_sdp_ram #(.W(EW), .DEPTH(N*N)) u_buf_a (
        .clk   (clk),
        .rst   (rst),
        .we    (hw && (wr_sel == SEL_A)),
        .waddr (wr_addr),
        .wdata (wr_data),
        .re    (iss_v && !phase2),
        .raddr ({iss_r, iss_k}),
        .rdata (a_q)
    );

    // B and C: right operands, banked by column parity
    cmm_bank2 #(.W(EW), .HDEPTH(N*N/2)) u_buf_b (
        .clk   (clk),
        .rst   (rst),
        .we_e  (hw && (wr_sel == SEL_B) && !wr_addr[0]),
        .we_o  (hw && (wr_sel == SEL_B) &&  wr_addr[0]),
        .waddr (wr_addr[AW-1:1]),
        .wd_e  (wr_data),
        .wd_o  (wr_data),
        .re    (iss_v && !phase2),
        .raddr ({iss_k, iss_cp}),
        .rq_e  (b_e),
        .rq_o  (b_o)
    );

    cmm_bank2 #(.W(EW), .HDEPTH(N*N/2)) u_buf_c (
        .clk   (clk),
        .rst   (rst),
        .we_e  (hw && (wr_sel == SEL_C) && !wr_addr[0]),
        .we_o  (hw && (wr_sel == SEL_C) &&  wr_addr[0]),
        .waddr (wr_addr[AW-1:1]),
        .wd_e  (wr_data),
        .wd_o  (wr_data),
        .re    (iss_v && phase2),
        .raddr ({iss_k, iss_cp}),
        .rq_e  (c_e),
        .rq_o  (c_o)
    );

    // T: written as column pairs, read back along a row
    cmm_bank2 #(.W(TEMP_W), .HDEPTH(N*N/2)) u_buf_t (
        .clk   (clk),
        .rst   (rst),
        .we_e  (wr_v && !phase2),
        .we_o  (wr_v && !phase2),
        .waddr ({wr_r, wr_cp}),
        .wd_e  (acc_v[0][TEMP_W-1:0]),
        .wd_o  (acc_v[1][TEMP_W-1:0]),
        .re    (iss_v && phase2),
        .raddr ({iss_r, iss_k[LOGN-1:1]}),
        .rq_e  (t_e),
        .rq_o  (t_o)
    );

    cmm_bank2 #(.W(OUT_W), .HDEPTH(N*N/2)) u_buf_d (
        .clk   (clk),
        .rst   (rst),
        .we_e  (wr_v && phase2),
        .we_o  (wr_v && phase2),
        .waddr ({wr_r, wr_cp}),
        .wd_e  (dx_v[0]),
        .wd_o  (dx_v[1]),
        .re    (rd_en),
        .raddr (rd_addr[AW-1:1]),
        .rq_e  (d_e),
        .rq_o  (d_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ksel_q   <= 1'b0;
            rd_lsb_q <= 1'b0;
        end else begin
            ksel_q <= iss_k[0];
            if (rd_en)
                rd_lsb_q <= rd_addr[0];
        end
    end

    assign lhs = phase2 ? (ksel_q ? t_o : t_e)
                        : {{(TEMP_W-EW){a_q[EW-1]}}, a_q};
    assign rhs_v[0] = phase2 ? c_e : b_e;
    assign rhs_v[1] = phase2 ? c_o : b_o;

    for (genvar m = 0; m < 2; m++) begin : g_mac
        cmm_mac #(.LW(TEMP_W), .RWD(EW), .ACC_W(ACC_W)) u_mac (
            .clk   (clk),
            .rst   (rst),
            .en    (mac_v),
            .first (mac_first),
            .lhs   (lhs),
            .rhs   (rhs_v[m]),
            .acc   (acc_v[m])
        );
        assign dx_v[m] = {{(OUT_W-ACC_W){acc_v[m][ACC_W-1]}}, acc_v[m]};
    end

    assign rd_data = rd_lsb_q ? d_o : d_e;
endmodule

// File: rtl/cmm_core_chk.sv
module cmm_core_chk #(
    parameter int N     = 16,
    parameter int OUT_W = 56
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   rd_en,
    input logic [OUT_W-1:0]       rd_data,
    input logic                   ready,
    input logic                   start,
    input logic                   iss_v
);
    localparam int LAT = N*N*N + 4;

    logic [31:0] since_start;

    always_ff @(posedge clk) begin
        if (rst || start)
            since_start <= '0;
        else
            since_start <= since_start + 1;
    end

    // R6: results become ready a fixed number of edges after the start
    a_r6_latency: assert property (@(posedge clk) disable iff (rst)
        $rose(ready) |-> since_start == LAT);

    // R6: no operand reads once results are declared ready
    a_r6_idle_when_ready: assert property (@(posedge clk) disable iff (rst)
        ready |-> !iss_v);

    // R6: ready holds until a new start
    a_r6_ready_holds: assert property (@(posedge clk) disable iff (rst)
        ready && !start |=> ready);

    // R9: restarting from ready drops the flag
    a_r9_restart_drops: assert property (@(posedge clk) disable iff (rst)
        start |=> !ready);

    // R8: read word holds when no read is requested
    a_r8_read_hold: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(rd_data));
endmodule

bind cmm_core cmm_core_chk #(.N(N), .OUT_W(OUT_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .rd_en   (rd_en),
    .rd_data (rd_data),
    .ready   (ready),
    .start   (start),
    .iss_v   (iss_v)
);

// File: tb/cmm_core_test.sv
`timescale 1ns/1ps
module cmm_core_test;
    localparam int N     = 4;
    localparam int EW    = 8;
    localparam int OUT_W = 56;
    localparam int AW    = $clog2(N*N);
    localparam int NN    = N*N;
    localparam int LAT   = N*N*N + 4;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             wr_en = 1'b0;
    logic [1:0]       wr_sel = '0;
    logic [AW-1:0]    wr_addr = '0;
    logic [EW-1:0]    wr_data = '0;
    logic             rd_en = 1'b0;
    logic [AW-1:0]    rd_addr = '0;
    logic [OUT_W-1:0] rd_data;
    logic             ready;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;
    int unsigned seed;

    longint ma [NN];
    longint mb [NN];
    longint mc [NN];
    longint md [NN];

    always #2.5 clk = ~clk;

    cmm_core #(.N(N), .EW(EW), .OUT_W(OUT_W)) uut (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_en   (rd_en),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .ready   (ready)
    );

    task automatic chk(input string tag, input longint act, input longint exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic longint rnd8();
        seed = seed * 32'd1103515245 + 32'd12345;
        return longint'($signed(seed[23:16]));
    endfunction

    task automatic compute();
        longint t [NN];
        for (int i = 0; i < N; i++)
            for (int j = 0; j < N; j++) begin
                t[i*N+j] = 0;
                for (int k = 0; k < N; k++)
                    t[i*N+j] += ma[i*N+k] * mb[k*N+j];
            end
        for (int i = 0; i < N; i++)
            for (int j = 0; j < N; j++) begin
                md[i*N+j] = 0;
                for (int k = 0; k < N; k++)
                    md[i*N+j] += t[i*N+k] * mc[k*N+j];
            end
    endtask

    // called at a falling edge; returns at the falling edge after the write
    task automatic host_wr(input logic [1:0] s, input int a, input longint d);
        wr_en   = 1'b1;
        wr_sel  = s;
        wr_addr = AW'(a);
        wr_data = EW'(d);
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic load(input bit junk);
        for (int i = 0; i < NN; i++) host_wr(2'b00, i, ma[i]);
        for (int i = 0; i < NN; i++) host_wr(2'b01, i, mb[i]);
        for (int i = 0; i < NN-1; i++) host_wr(2'b10, i, mc[i]);
        if (junk)   // R2: unused select code across every address
            for (int i = 0; i < NN; i++) host_wr(2'b11, i, 8'h5A);
        host_wr(2'b10, NN-1, mc[NN-1]);
    endtask

    task automatic wait_ready(input int cyc0, input string tag);
        int cyc = cyc0;
        if (cyc0 == 0)
            chk("R6 ready low after start", longint'(ready), 0);
        while (!ready && cyc < LAT + 50) begin
            @(negedge clk);
            cyc++;
        end
        chk(tag, cyc, LAT);
    endtask

    task automatic check_d(input string tag);
        for (int i = 0; i < NN; i++) begin
            rd_en   = 1'b1;
            rd_addr = AW'(i);
            @(negedge clk);
            rd_en = 1'b0;
            chk(tag, longint'($signed(rd_data)), md[i]);
        end
        // R8: with the strobe low a new address must not change the word
        rd_addr = '0;
        @(negedge clk);
        chk("R8 read word holds", longint'($signed(rd_data)), md[NN-1]);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            n_cmp++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R6 ready low after reset", longint'(ready), 0);

        // pattern 0: identity around B, so D must equal B (R1 R3)
        for (int i = 0; i < NN; i++) begin
            ma[i] = (i / N == i % N) ? 1 : 0;
            mc[i] = ma[i];
            mb[i] = i * 7 - 50;
        end
        compute();
        load(1'b0);
        wait_ready(0, "R6 latency identity");
        check_d("R1 R3 identity operands");

        // pattern 1: all minimum values, largest negative result (R4)
        for (int i = 0; i < NN; i++) begin
            ma[i] = -128; mb[i] = -128; mc[i] = -128;
        end
        compute();
        load(1'b0);
        wait_ready(0, "R6 latency minimum");
        check_d("R4 R3 minimum operands");

        // pattern 2: mixed extremes
        for (int i = 0; i < NN; i++) begin
            ma[i] = 127; mb[i] = -128; mc[i] = (i % 2 == 0) ? 127 : -128;
        end
        compute();
        load(1'b0);
        wait_ready(0, "R6 latency extremes");
        check_d("R3 R4 mixed extremes");

        // pattern 3: random operands with a select-11 sweep before the start
        seed = 32'h1234_5678;
        for (int i = 0; i < NN; i++) begin
            ma[i] = rnd8(); mb[i] = rnd8(); mc[i] = rnd8();
        end
        compute();
        load(1'b1);
        wait_ready(0, "R6 latency random");
        check_d("R2 select 11 ignored");

        // pattern 4: writes issued while busy must be ignored (R7)
        seed = 32'h0BAD_F00D;
        for (int i = 0; i < NN; i++) begin
            ma[i] = rnd8(); mb[i] = rnd8(); mc[i] = rnd8();
        end
        compute();
        load(1'b0);
        chk("R6 ready low after start", longint'(ready), 0);
        for (int i = 0; i < NN; i++) host_wr(2'b00, i, 8'h33);
        host_wr(2'b10, NN-1, 8'h11);
        wait_ready(NN + 1, "R7 busy start ignored");
        check_d("R7 busy writes ignored");

        // R5: a non-final C write leaves the results ready
        mc[0] = -77;
        host_wr(2'b10, 0, mc[0]);
        chk("R5 non-final C write no start", longint'(ready), 1);

        // R9: restart from ready with the changed C
        compute();
        host_wr(2'b10, NN-1, mc[NN-1]);
        chk("R9 restart drops ready", longint'(ready), 0);
        wait_ready(0, "R9 restart latency");
        check_d("R9 recompute after restart");

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule